// File: doc/BRIEF.md
# Byte-Aligning Serial Deframer

This block takes a serial SONET/SDH bit stream, one bit per cycle of its bit clock, and turns it into bytes. It makes a byte clock at one eighth of the bit rate and a reference clock at a divided rate chosen by a line-rate select. It also drives a sync strobe that marks each framing pattern. The framing pattern is three A1 bytes (8'hF6) followed by three A2 bytes (8'h28). It is watched for in a 48-bit window of the most recent serial bits, at every bit offset.

The byte boundary is a rotation from 0 to 7 that picks which 8 bits of the window form the next output byte. A rising edge on the out-of-frame input starts a search. The first framing match found during that search sets the rotation, and the rotation then stays fixed until the next such edge. Matches seen at any time still raise the sync strobe, whether or not a search is running. A disable input makes the block ignore out-of-frame edges.

Top module: `sonet_byte_framer`

## Requirements
- R1: While reset is low: par_out is 0, sync_out is 0, byte_clk is 1 and ref_clk is 1. The rotation is 0 and no search is running.
- R2: byte_clk repeats every 8 bit-clock cycles, 4 high then 4 low, and starts high on the first cycle after reset.
- R3: With rate_sel=1 (STS-12), ref_clk has a period of 12 bit-clock cycles, 6 high then 6 low. With rate_sel=0 (STS-3), the period is 3 cycles, 1 high then 2 low.
- R4: Serial bits arrive most significant first. par_out changes only on the bit-clock edge where byte_clk falls (the load edge). With rotation r, the loaded byte is the 8 bits whose last bit was sampled r+1 edges before the load edge; the first-sampled bit goes to par_out[7] and the last to par_out[0].
- R5: When the last 48 sampled bits equal 48'hF6F6F6282828, sync_out goes high at the next load edge (or at the same edge, if the match is seen at that edge) and stays high for exactly 8 bit-clock cycles. This holds at any bit offset and at any level of oof_in.
- R6: During a search, the first match sets the rotation. At the next load edge, par_out shows the final A2 byte (8'h28) and sync_out is high.
- R7: Once locked, a match at a different bit offset raises sync_out but leaves the rotation unchanged.
- R8: Holding oof_in high, or driving a falling edge on it, neither starts a search nor changes the rotation.
- R9: While recov_dis is 1, a rising edge on oof_in is ignored.
- R10: A search has no time limit. A new rising edge on oof_in during a search restarts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_in | input | 1 | Serial data, one bit per clock |
| oof_in | input | 1 | Out-of-frame indication; a rising edge starts a search |
| recov_dis | input | 1 | 1 = ignore out-of-frame edges |
| rate_sel | input | 1 | 1 = STS-12 (ref divide by 12), 0 = STS-3 (divide by 3) |
| par_out | output | 8 | Aligned byte output |
| sync_out | output | 1 | Framing pattern strobe, one byte period |
| byte_clk | output | 1 | Bit clock divided by 8 |
| ref_clk | output | 1 | Bit clock divided by 12 or 3 |

## Verification
byte_clk and ref_clk are registered, so each shows its new counter state one bit-clock edge after the counter steps. par_out and sync_out change only on the load edge. That load edge is the one on which byte_clk falls, so a match is seen on par_out and sync_out between 1 and 8 edges after the final pattern bit has been sampled. The bench drives each bit, advances its own cycle model by that same single edge, and compares all four outputs at the following falling clock edge. The directed framing checks latch par_out at the first high sample of sync_out, so they check the byte that arrives together with the strobe.

// File: rtl/sbf_pkg.sv
package sbf_pkg;
  typedef enum logic {
    RATE_STS3  = 1'b0,
    RATE_STS12 = 1'b1
  } rate_e;
endpackage

// File: rtl/sbf_byte_timer.sv
module sbf_byte_timer #(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned CW = $clog2(BYTE_W)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [CW-1:0] phase_q,
  output logic          load_c,
  output logic          byte_clk_q
);
  localparam logic [CW-1:0] HALF_V = CW'(BYTE_W / 2);
  localparam logic [CW-1:0] LOAD_V = CW'(BYTE_W / 2 - 1);

  logic [CW-1:0] phase_d;
  logic          bclk_d;

  always_comb begin
    phase_d = phase_q + 1'b1;
    bclk_d  = (phase_d < HALF_V);
    load_c  = (phase_q == LOAD_V);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q    <= '0;
      byte_clk_q <= 1'b1;
    end else begin
      phase_q    <= phase_d;
      byte_clk_q <= bclk_d;
    end
  end
endmodule

// File: rtl/sbf_ref_divider.sv
module sbf_ref_divider
  import sbf_pkg::*;
#(
  parameter int unsigned DIV_FAST = 12,
  parameter int unsigned DIV_SLOW = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rate_sel,
  output logic ref_clk_q
);
  localparam int unsigned DMAX = (DIV_FAST > DIV_SLOW) ? DIV_FAST : DIV_SLOW;
  localparam int unsigned RW   = $clog2(DMAX);

  logic [RW-1:0] cnt_q, cnt_d, lim, half;
  logic          ref_d;

  always_comb begin
    if (rate_e'(rate_sel) == RATE_STS12) begin
      lim  = RW'(DIV_FAST - 1);
      half = RW'(DIV_FAST / 2);
    end else begin
      lim  = RW'(DIV_SLOW - 1);
      half = RW'(DIV_SLOW / 2);
    end
    cnt_d = (cnt_q >= lim) ? '0 : cnt_q + 1'b1;
    ref_d = (cnt_d < half);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      ref_clk_q <= 1'b1;
    end else begin
      cnt_q     <= cnt_d;
      ref_clk_q <= ref_d;
    end
  end
endmodule

// File: rtl/sbf_window_matcher.sv
module sbf_window_matcher #(
  parameter int unsigned   BYTE_W = 8,
  parameter int unsigned   NREP   = 3,
  parameter logic [BYTE_W-1:0] A1_VAL = 8'hF6,
  parameter logic [BYTE_W-1:0] A2_VAL = 8'h28,
  localparam int unsigned  WIN    = 2 * NREP * BYTE_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ser_in,
  output logic [WIN-1:0] win_q,
  output logic           match_c
);
  logic [WIN-1:0] pat;
  logic [WIN-1:0] win_d;

  // Newest bits sit at the low end, so the A2 run occupies the low slots.
  for (genvar g = 0; g < 2 * NREP; g++) begin : g_slot
    if (g < NREP) begin : g_a2
      assign pat[g*BYTE_W +: BYTE_W] = A2_VAL;
    end else begin : g_a1
      assign pat[g*BYTE_W +: BYTE_W] = A1_VAL;
    end
  end

  always_comb begin
    win_d   = {win_q[WIN-2:0], ser_in};
    match_c = (win_q == pat);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) win_q <= '0;
    else        win_q <= win_d;
  end
endmodule

// File: rtl/sbf_align_ctrl.sv
module sbf_align_ctrl #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned WIN    = 48,
  localparam int unsigned CW    = $clog2(BYTE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CW-1:0]     phase_q,
  input  logic              load_c,
  input  logic [WIN-1:0]    win_q,
  input  logic              match_c,
  input  logic              oof_in,
  input  logic              recov_dis,
  output logic [BYTE_W-1:0] par_q,
  output logic              sync_q
);
  localparam logic [CW-1:0] LOAD_V = CW'(BYTE_W / 2 - 1);

  logic [CW-1:0]     rot_q, rot_d;
  logic              srch_q, srch_d;
  logic              pend_q, pend_d;
  logic              oof_q;
  logic              rise_c;
  logic [WIN-1:0]    shifted;
  logic [BYTE_W-1:0] par_d;
  logic              sync_d;

  always_comb begin
    rise_c = oof_in & ~oof_q & ~recov_dis;
    rot_d  = rot_q;
    srch_d = srch_q;
    if (rise_c) begin
      srch_d = 1'b1;
    end else if (srch_q && match_c) begin
      srch_d = 1'b0;
      // distance from the match cycle to the load cycle, modulo a byte
      rot_d  = LOAD_V - phase_q;
    end
    shifted = win_q >> rot_d;
    if (load_c) begin
      par_d  = shifted[BYTE_W-1:0];
      sync_d = pend_q | match_c;
      pend_d = 1'b0;
    end else begin
      par_d  = par_q;
      sync_d = sync_q;
      pend_d = pend_q | match_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rot_q  <= '0;
      srch_q <= 1'b0;
      pend_q <= 1'b0;
      oof_q  <= 1'b0;
      par_q  <= '0;
      sync_q <= 1'b0;
    end else begin
      rot_q  <= rot_d;
      srch_q <= srch_d;
      pend_q <= pend_d;
      oof_q  <= oof_in;
      par_q  <= par_d;
      sync_q <= sync_d;
    end
  end
endmodule

// File: rtl/sonet_byte_framer.sv
module sonet_byte_framer #(
  parameter int unsigned       BYTE_W   = 8,
  parameter int unsigned       NREP     = 3,
  parameter logic [BYTE_W-1:0] A1_VAL   = 8'hF6,
  parameter logic [BYTE_W-1:0] A2_VAL   = 8'h28,
  parameter int unsigned       DIV_FAST = 12,
  parameter int unsigned       DIV_SLOW = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_in,
  input  logic              oof_in,
  input  logic              recov_dis,
  input  logic              rate_sel,
  output logic [BYTE_W-1:0] par_out,
  output logic              sync_out,
  output logic              byte_clk,
  output logic              ref_clk
);
  localparam int unsigned CW  = $clog2(BYTE_W);
  localparam int unsigned WIN = 2 * NREP * BYTE_W;

  logic [CW-1:0]  phase;
  logic           load;
  logic [WIN-1:0] win;
  logic           match;

  sbf_byte_timer #(.BYTE_W(BYTE_W)) timer_i (
    .clk(clk), .rst_n(rst_n), .phase_q(phase), .load_c(load), .byte_clk_q(byte_clk)
  );

  sbf_ref_divider #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) refdiv_i (
    .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .ref_clk_q(ref_clk)
  );

  sbf_window_matcher #(
    .BYTE_W(BYTE_W), .NREP(NREP), .A1_VAL(A1_VAL), .A2_VAL(A2_VAL)
  ) match_i (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .win_q(win), .match_c(match)
  );

  sbf_align_ctrl #(.BYTE_W(BYTE_W), .WIN(WIN)) align_i (
    .clk(clk), .rst_n(rst_n), .phase_q(phase), .load_c(load), .win_q(win),
    .match_c(match), .oof_in(oof_in), .recov_dis(recov_dis),
    .par_q(par_out), .sync_q(sync_out)
  );
endmodule

// File: rtl/sbf_checker.sv
module sbf_checker #(
  parameter int unsigned BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              byte_clk,
  input logic [BYTE_W-1:0] par_out,
  input logic              sync_out
);
  localparam int unsigned HALF = BYTE_W / 2;

  logic       bclk_q;
  logic [7:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q <= 1'b1;
      run_q  <= '0;
    end else begin
      bclk_q <= byte_clk;
      run_q  <= (byte_clk != bclk_q) ? 8'd1 : run_q + 8'd1;
    end
  end

  p_byteclk_max_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= 8'(HALF));

  p_byteclk_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_clk != bclk_q) |-> (run_q == 8'(HALF)));

  p_par_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(byte_clk) |-> $stable(par_out));

  p_sync_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(byte_clk) |-> $stable(sync_out));

  p_sync_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_out) |=> sync_out);
endmodule

bind sonet_byte_framer sbf_checker #(.BYTE_W(BYTE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .byte_clk(byte_clk), .par_out(par_out), .sync_out(sync_out)
);

// File: tb/sonet_byte_framer_tb_top.sv
`timescale 1ns/1ps
module sonet_byte_framer_tb_top;
  localparam logic [47:0] PAT = 48'hF6F6F6282828;

  logic       clk;
  logic       rst_n;
  logic       ser_in;
  logic       oof_in;
  logic       recov_dis;
  logic       rate_sel;
  logic [7:0] par_out;
  logic       sync_out;
  logic       byte_clk;
  logic       ref_clk;

  int vectors;
  int miscomp;
  bit done;

  sonet_byte_framer dut_i (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .oof_in(oof_in),
    .recov_dis(recov_dis), .rate_sel(rate_sel), .par_out(par_out),
    .sync_out(sync_out), .byte_clk(byte_clk), .ref_clk(ref_clk)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // bench model state, built from the requirements
  bit [47:0] m_hist;
  int        m_cnt, m_ref, m_rot;
  bit        m_srch, m_pend, m_oofq, m_sync, m_bclk, m_rclk;
  bit [7:0]  m_par;
  bit        cur_oof;
  bit        sync_seen;
  bit [7:0]  sync_par;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscomp++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_step(input bit b, input bit oof);
    bit match, rise, load;
    int rot_n, n;
    bit [47:0] sh;
    match = (m_hist == PAT);
    rise  = oof && !m_oofq && !recov_dis;
    load  = (m_cnt == 3);
    rot_n = m_rot;
    if (rise) m_srch = 1'b1;
    else if (m_srch && match) begin
      m_srch = 1'b0;
      rot_n  = (3 - m_cnt) & 7;
    end
    m_rot = rot_n;
    if (load) begin
      sh     = m_hist >> rot_n;
      m_par  = sh[7:0];
      m_sync = m_pend | match;
      m_pend = 1'b0;
    end else begin
      m_pend = m_pend | match;
    end
    m_hist = {m_hist[46:0], b};
    m_cnt  = (m_cnt + 1) % 8;
    m_bclk = (m_cnt < 4);
    n = rate_sel ? 12 : 3;
    if (m_ref >= n - 1) m_ref = 0; else m_ref = m_ref + 1;
    m_rclk = (m_ref < n / 2);
    m_oofq = oof;
  endtask

  task automatic step(input bit b, input string tag);
    ser_in = b;
    oof_in = cur_oof;
    model_step(b, cur_oof);
    @(posedge clk);
    @(negedge clk);
    chk(byte_clk === m_bclk, "R2", "byte_clk", 32'(byte_clk), 32'(m_bclk));
    chk(ref_clk === m_rclk, "R3", "ref_clk", 32'(ref_clk), 32'(m_rclk));
    chk(par_out === m_par, tag, "par_out", 32'(par_out), 32'(m_par));
    chk(sync_out === m_sync, "R5", "sync_out", 32'(sync_out), 32'(m_sync));
    if (sync_out === 1'b1 && !sync_seen) begin
      sync_seen = 1'b1;
      sync_par  = par_out;
    end
  endtask

  task automatic send_byte(input bit [7:0] v, input string tag);
    for (int i = 7; i >= 0; i--) step(v[i], tag);
  endtask

  task automatic pad(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, tag);
  endtask

  task automatic send_pat(input string tag);
    for (int i = 0; i < 3; i++) send_byte(8'hF6, tag);
    for (int i = 0; i < 3; i++) send_byte(8'h28, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      vectors++;
      miscomp++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
      $finish;
    end
  end

  initial begin
    int r;
    vectors = 0; miscomp = 0; done = 1'b0;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; ser_in = 1'b0; oof_in = 1'b0; recov_dis = 1'b0; rate_sel = 1'b1;
    cur_oof = 1'b0;
    m_hist = '0; m_cnt = 0; m_ref = 0; m_rot = 0; m_srch = 0; m_pend = 0;
    m_oofq = 0; m_sync = 0; m_bclk = 1; m_rclk = 1; m_par = '0;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(par_out === 8'h00, "R1", "par_out", 32'(par_out), 32'h0);
    chk(sync_out === 1'b0, "R1", "sync_out", 32'(sync_out), 32'h0);
    chk(byte_clk === 1'b1, "R1", "byte_clk", 32'(byte_clk), 32'h1);
    chk(ref_clk === 1'b1, "R1", "ref_clk", 32'(ref_clk), 32'h1);
    rst_n = 1'b1;

    // R4 random data at rotation 0, STS-12 reference
    for (int i = 0; i < 200; i++) step(1'($urandom % 2), "R4");

    // R3 STS-3 reference divider
    rate_sel = 1'b0;
    for (int i = 0; i < 60; i++) step(1'($urandom % 2), "R3");
    rate_sel = 1'b1;
    pad(64, "R4");

    // R6 search locks to the pattern
    sync_seen = 1'b0;
    cur_oof = 1'b1;
    pad(5, "R6");
    send_pat("R6");
    send_byte(8'h5A, "R6");
    send_byte(8'hC3, "R6");
    chk(sync_seen, "R6", "sync seen", 32'(sync_seen), 32'h1);
    chk(sync_par === 8'h28, "R6", "byte with sync", 32'(sync_par), 32'h28);

    // R7 locked: shifted pattern pulses sync, no realignment (oof still high)
    sync_seen = 1'b0;
    pad(3, "R7");
    send_pat("R7");
    send_byte(8'hFF, "R7");
    send_byte(8'hFF, "R7");
    chk(sync_seen, "R5", "sync seen shifted", 32'(sync_seen), 32'h1);
    chk(sync_par !== 8'h28, "R7", "byte with sync not 28", 32'(sync_par), 32'h28);

    // R8 falling edge does nothing
    sync_seen = 1'b0;
    cur_oof = 1'b0;
    pad(2, "R8");
    send_pat("R8");
    send_byte(8'hFF, "R8");
    send_byte(8'hFF, "R8");
    chk(sync_seen, "R5", "sync seen after fall", 32'(sync_seen), 32'h1);
    chk(sync_par !== 8'h28, "R8", "byte with sync not 28", 32'(sync_par), 32'h28);

    // R9 recovery disabled ignores a rising edge
    sync_seen = 1'b0;
    recov_dis = 1'b1;
    cur_oof = 1'b1;
    pad(1, "R9");
    send_pat("R9");
    send_byte(8'hFF, "R9");
    send_byte(8'hFF, "R9");
    chk(sync_seen, "R5", "sync seen disabled", 32'(sync_seen), 32'h1);
    chk(sync_par !== 8'h28, "R9", "byte with sync not 28", 32'(sync_par), 32'h28);
    recov_dis = 1'b0;

    // R10 restart and unbounded search
    cur_oof = 1'b0;
    pad(1, "R10");
    cur_oof = 1'b1;
    pad(20, "R10");
    cur_oof = 1'b0;
    pad(2, "R10");
    cur_oof = 1'b1;
    pad(300, "R10");
    pad(3, "R10");
    sync_seen = 1'b0;
    send_pat("R10");
    send_byte(8'h5A, "R10");
    chk(sync_seen, "R10", "sync seen after restart", 32'(sync_seen), 32'h1);
    chk(sync_par === 8'h28, "R10", "byte with sync", 32'(sync_par), 32'h28);

    // mixed random traffic
    for (int k = 0; k < 400; k++) begin
      r = int'($urandom % 16);
      if (k % 100 == 99) rate_sel = 1'($urandom % 2);
      if (r == 0) send_pat("R5");
      else if (r == 1) begin cur_oof = ~cur_oof; step(1'($urandom % 2), "R6"); end
      else if (r == 2) begin recov_dis = 1'($urandom % 2); step(1'b0, "R9"); end
      else if (r == 3) step(1'($urandom % 2), "R7");
      else send_byte(8'($urandom % 256), "R4");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
    $finish;
  end
endmodule